// File: doc/BRIEF.md
# Hash Engine Register and Interrupt Front End

This block is the register-mapped control and status face of a hash engine that computes one of four digests (MD5, SHA-1, SHA-224, SHA-256). Software reaches it through a plain 32-bit word port. Through that port it can:

- hold the engine in soft reset and release it;
- program the 64-bit message length in bits;
- choose the algorithm and the byte-lane order;
- manage the interrupt status, enable and clear registers;
- drain the finished digest by reading one address repeatedly, each read popping one word from a small result queue.

On the core side the block presents the programmed configuration, a configured flag and the soft-reset level. It accepts digest words over a valid/ready push stream whose last beat marks a finished result set. A single strobe reports message words arriving from the data path. Three status bits report protocol misuse:

- results seen before the set is complete;
- a pop from an empty queue;
- a message word written before configuration.

The push stream follows valid/ready rules. A word is taken on a rising clock edge where `dig_valid` and `dig_ready` are both high. `dig_ready` is low while the queue is full or while soft reset is held, and the producer must then hold its word. The block never drops an offered word.

Top module: `hash_regfront`

## Requirements
- R1: After `rst_n` is asserted, every register reads 0. In that state `irq` and `core_rst` are 0, `cfg_valid` is 0 and `dig_ready` is 1 (queue empty).
- R2: Writes to word offsets 0x04 (upper half) and 0x08 (lower half) read back unchanged. Together they drive `cfg_len` as {upper, lower}.
- R3: A write to the control offset 0x0C stores the algorithm in bits [1:0] (0 MD5, 1 SHA-1, 2 SHA-224, 3 SHA-256) and the byte-order code in bits [9:8]. These drive `cfg_algo` and `cfg_order`. Every other control bit reads 0. The write also sets `cfg_valid` from the next cycle.
- R4: Writing bit 0 of offset 0x00 as 1 holds the engine in soft reset: `core_rst` is 1, `dig_ready` is 0, and status bits [3:0], the queue and `cfg_valid` are cleared. Writing 0 releases it. Length, control and enable contents survive soft reset.
- R5: The queue at offset 0x1C holds 8 words. Reads return pushed words in push order, one word per read, with read data valid in the cycle after the read strobe. `dig_ready` is 0 while 8 words are held.
- R6: A read of 0x1C with the queue empty returns 0, sets status bit 2 and leaves the queue unchanged.
- R7: Every accepted push sets status bit 0. An accepted push with `dig_last` high also sets status bit 1.
- R8: A `msg_wr` pulse while `cfg_valid` is 0 sets status bit 3. While `cfg_valid` is 1 the pulse has no effect.
- R9: Writing a mask to offset 0x18 clears the matching status bits [3:0]. An event on the same bit in the same cycle wins, leaving that bit set.
- R10: Status bit 8 at offset 0x10 reads 1 exactly while the queue is non-empty, and clear writes do not affect it. `irq` is the OR of status ANDed with the enable register at offset 0x14 (bits [8:0]).
- R11: Writes to the status offset 0x10 have no effect on the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| core_rst | output | 1 | Soft reset level to the hash datapath |
| cfg_valid | output | 1 | Control register has been written since the last reset |
| cfg_algo | output | 2 | Algorithm select |
| cfg_order | output | 2 | Byte-lane order code |
| cfg_len | output | 64 | Message length in bits |
| msg_wr | input | 1 | Pulse for each message word reaching the datapath |
| dig_valid | input | 1 | Digest word offered |
| dig_ready | output | 1 | Queue can take a digest word |
| dig_data | input | 32 | Digest word |
| dig_last | input | 1 | Offered word ends a result set |
| irq | output | 1 | Interrupt request |

## Verification
A queue pointer or count that goes wrong shows up in two places. The next read of 0x1C returns a word out of push order or a stale word, and `dig_ready` or status bit 8 disagrees with the number of words outstanding. Both are visible within one read of the fault. A status bit that sets or clears wrongly is seen on `irq` in the same cycle whenever that bit is enabled. The bench therefore compares `irq` after every operation and mixes random enable masks with clears issued on the same cycle as events. A soft reset that leaves state behind appears as a nonzero pop, a set `cfg_valid` or a low `dig_ready` right after release.

// File: rtl/hrf_pkg.sv
`timescale 1ns/1ps
package hrf_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int NUM_EV = 4;
  localparam int STAT_W = 9;

  localparam logic [ADDR_W-1:0] OFF_SRST  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_LENHI = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_LENLO = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_ENAB  = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 5'h18;
  localparam logic [ADDR_W-1:0] OFF_QUEUE = 5'h1C;

  typedef enum logic [1:0] {
    ALG_MD5    = 2'd0,
    ALG_SHA1   = 2'd1,
    ALG_SHA224 = 2'd2,
    ALG_SHA256 = 2'd3
  } algo_e;

  typedef enum logic [1:0] {
    LANES_3210 = 2'd0,
    LANES_0123 = 2'd1,
    LANES_2310 = 2'd2,
    LANES_1032 = 2'd3
  } order_e;

  localparam int EV_AVAIL = 0;
  localparam int EV_DONE  = 1;
  localparam int EV_EMPTY = 2;
  localparam int EV_EARLY = 3;
endpackage

// File: rtl/hrf_fifo.sv
`timescale 1ns/1ps
module hrf_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (PW+1)'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/hrf_irq.sv
`timescale 1ns/1ps
module hrf_irq
  import hrf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [NUM_EV-1:0] ev,
  input  logic              clr_we,
  input  logic [NUM_EV-1:0] clr_mask,
  input  logic              q_level,
  input  logic [STAT_W-1:0] enable,
  output logic [STAT_W-1:0] status_vec,
  output logic              irq
);
  logic [NUM_EV-1:0] stat_q;

  for (genvar i = 0; i < NUM_EV; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stat_q[i] <= 1'b0;
      else if (flush)  stat_q[i] <= 1'b0;
      else if (ev[i])  stat_q[i] <= 1'b1;
      else if (clr_we && clr_mask[i]) stat_q[i] <= 1'b0;
    end
  end

  assign status_vec = {q_level, {(STAT_W-1-NUM_EV){1'b0}}, stat_q};
  assign irq        = |(status_vec & enable);
endmodule

// File: rtl/hash_regfront.sv
`timescale 1ns/1ps
module hash_regfront
  import hrf_pkg::*;
#(
  parameter int Q_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              core_rst,
  output logic              cfg_valid,
  output logic [1:0]        cfg_algo,
  output logic [1:0]        cfg_order,
  output logic [63:0]       cfg_len,
  input  logic              msg_wr,
  input  logic              dig_valid,
  output logic              dig_ready,
  input  logic [DATA_W-1:0] dig_data,
  input  logic              dig_last,
  output logic              irq
);
  logic              sreset_q;
  logic [DATA_W-1:0] len_hi_q, len_lo_q;
  algo_e             algo_q;
  order_e            order_q;
  logic              cfg_q;
  logic [STAT_W-1:0] en_q;
  logic [STAT_W-1:0] status_vec;
  logic [DATA_W-1:0] q_head;
  logic              q_empty, q_full;
  logic              push_ok, pop_req, clr_we;
  logic [NUM_EV-1:0] ev;
  logic [DATA_W-1:0] rd_mux;

  function automatic logic wr_hit(input logic [ADDR_W-1:0] off);
    return reg_wr_en && (reg_addr == off);
  endfunction

  assign dig_ready = !q_full && !sreset_q;
  assign push_ok   = dig_valid && dig_ready;
  assign pop_req   = reg_rd_en && (reg_addr == OFF_QUEUE) && !sreset_q;
  assign clr_we    = wr_hit(OFF_CLR);

  always_comb begin
    ev           = '0;
    ev[EV_AVAIL] = push_ok;
    ev[EV_DONE]  = push_ok && dig_last;
    ev[EV_EMPTY] = pop_req && q_empty;
    ev[EV_EARLY] = msg_wr && !cfg_q && !sreset_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreset_q <= 1'b0;
      len_hi_q <= '0;
      len_lo_q <= '0;
      algo_q   <= ALG_MD5;
      order_q  <= LANES_3210;
      cfg_q    <= 1'b0;
      en_q     <= '0;
    end else begin
      if (wr_hit(OFF_SRST))  sreset_q <= reg_wdata[0];
      if (wr_hit(OFF_LENHI)) len_hi_q <= reg_wdata;
      if (wr_hit(OFF_LENLO)) len_lo_q <= reg_wdata;
      if (wr_hit(OFF_ENAB))  en_q     <= reg_wdata[STAT_W-1:0];
      if (wr_hit(OFF_CTRL)) begin
        algo_q  <= algo_e'(reg_wdata[1:0]);
        order_q <= order_e'(reg_wdata[9:8]);
      end
      if (sreset_q)              cfg_q <= 1'b0;
      else if (wr_hit(OFF_CTRL)) cfg_q <= 1'b1;
    end
  end

  hrf_fifo #(.W(DATA_W), .DEPTH(Q_DEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (sreset_q),
    .push      (push_ok),
    .push_data (dig_data),
    .pop       (pop_req),
    .head      (q_head),
    .empty     (q_empty),
    .full      (q_full)
  );

  hrf_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (sreset_q),
    .ev         (ev),
    .clr_we     (clr_we),
    .clr_mask   (reg_wdata[NUM_EV-1:0]),
    .q_level    (!q_empty),
    .enable     (en_q),
    .status_vec (status_vec),
    .irq        (irq)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      OFF_SRST:  rd_mux = {{(DATA_W-1){1'b0}}, sreset_q};
      OFF_LENHI: rd_mux = len_hi_q;
      OFF_LENLO: rd_mux = len_lo_q;
      OFF_CTRL:  rd_mux = {22'b0, order_q, 6'b0, algo_q};
      OFF_STAT:  rd_mux = {{(DATA_W-STAT_W){1'b0}}, status_vec};
      OFF_ENAB:  rd_mux = {{(DATA_W-STAT_W){1'b0}}, en_q};
      OFF_QUEUE: rd_mux = sreset_q ? '0 : q_head;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reg_rdata <= '0;
    else if (reg_rd_en) reg_rdata <= rd_mux;
  end

  assign core_rst  = sreset_q;
  assign cfg_valid = cfg_q;
  assign cfg_algo  = algo_q;
  assign cfg_order = order_q;
  assign cfg_len   = {len_hi_q, len_lo_q};
endmodule

// File: rtl/hrf_chk.sv
`timescale 1ns/1ps
module hrf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sreset_q,
  input logic       cfg_valid,
  input logic       dig_valid,
  input logic       dig_ready,
  input logic       q_full,
  input logic       q_empty,
  input logic       pop_req,
  input logic       msg_wr,
  input logic       clr_we,
  input logic [3:0] clr_mask,
  input logic [8:0] status_vec
);
  // R5
  full_blocks_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !dig_ready);

  // R6
  empty_pop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && q_empty) |=> status_vec[2]);

  // R4
  srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sreset_q |=> (!cfg_valid && status_vec[3:0] == 4'b0 && !status_vec[8]));

  // R8
  early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_wr && !cfg_valid && !sreset_q) |=> status_vec[3]);

  // R9
  clear_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_mask[0] && !(dig_valid && dig_ready)) |=> !status_vec[0]);

  // R10
  level_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_vec[8] == !q_empty);
endmodule

bind hash_regfront hrf_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sreset_q   (sreset_q),
  .cfg_valid  (cfg_valid),
  .dig_valid  (dig_valid),
  .dig_ready  (dig_ready),
  .q_full     (q_full),
  .q_empty    (q_empty),
  .pop_req    (pop_req),
  .msg_wr     (msg_wr),
  .clr_we     (clr_we),
  .clr_mask   (reg_wdata[3:0]),
  .status_vec (status_vec)
);

// File: tb/sim_hash_regfront.sv
`timescale 1ns/1ps
module sim_hash_regfront;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        core_rst, cfg_valid;
  logic [1:0]  cfg_algo, cfg_order;
  logic [63:0] cfg_len;
  logic        msg_wr = 1'b0;
  logic        dig_valid = 1'b0;
  logic        dig_ready;
  logic [31:0] dig_data = '0;
  logic        dig_last = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [31:0] mq[$];
  logic [3:0]  ms = '0;
  logic [8:0]  men = '0;
  logic        mcfg = 1'b0;

  always #2.5 clk = ~clk;

  hash_regfront u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .core_rst(core_rst), .cfg_valid(cfg_valid), .cfg_algo(cfg_algo),
    .cfg_order(cfg_order), .cfg_len(cfg_len), .msg_wr(msg_wr),
    .dig_valid(dig_valid), .dig_ready(dig_ready), .dig_data(dig_data),
    .dig_last(dig_last), .irq(irq)
  );

  function automatic logic [8:0] exp_stat();
    return {(mq.size() != 0), 4'b0, ms};
  endfunction

  function automatic logic exp_irq();
    return |(exp_stat() & men);
  endfunction

  function automatic logic [31:0] ctrl_rb(input logic [31:0] w);
    return w & 32'h0000_0303;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic push(input logic [31:0] d, input logic last);
    logic exp_rdy;
    exp_rdy = (mq.size() < 8);
    chk("R5 dig_ready", {63'b0, dig_ready}, {63'b0, exp_rdy});
    dig_valid = 1'b1; dig_data = d; dig_last = last;
    @(negedge clk);
    dig_valid = 1'b0; dig_last = 1'b0;
    if (exp_rdy) begin
      mq.push_back(d);
      ms[0] = 1'b1;
      if (last) ms[1] = 1'b1;
    end
  endtask

  task automatic pop_chk(input string tag);
    logic [31:0] d, e;
    rd(5'h1C, d);
    if (mq.size() == 0) begin e = 0; ms[2] = 1'b1; end
    else e = mq.pop_front();
    chk(tag, {32'b0, d}, {32'b0, e});
  endtask

  task automatic stat_chk(input string tag);
    logic [31:0] d;
    rd(5'h10, d);
    chk(tag, {32'b0, d}, {55'b0, exp_stat()});
  endtask

  task automatic pulse_msg();
    msg_wr = 1'b1;
    @(negedge clk);
    msg_wr = 1'b0;
    if (!mcfg) ms[3] = 1'b1;
  endtask

  task automatic soft_reset();
    wr(5'h00, 32'h1);
    wr(5'h00, 32'h0);
    mq.delete(); ms = '0; mcfg = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, h, l;
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {63'b0, irq}, 64'd0);
    chk("R1 core_rst", {63'b0, core_rst}, 64'd0);
    chk("R1 cfg_valid", {63'b0, cfg_valid}, 64'd0);
    chk("R1 dig_ready", {63'b0, dig_ready}, 64'd1);
    for (int a = 0; a < 7; a++) begin
      rd(5'(a * 4), d);
      chk("R1 reg zero", {32'b0, d}, 64'd0);
    end

    // R2 length
    h = $urandom(); l = $urandom();
    wr(5'h04, h); wr(5'h08, l);
    rd(5'h04, d); chk("R2 hi readback", {32'b0, d}, {32'b0, h});
    rd(5'h08, d); chk("R2 lo readback", {32'b0, d}, {32'b0, l});
    chk("R2 cfg_len", cfg_len, {h, l});

    // R8 early message write sets bit3
    pulse_msg();
    stat_chk("R8 early bit");

    // R3 control
    wr(5'h0C, 32'hFFFF_FFFF);
    mcfg = 1'b1;
    rd(5'h0C, d); chk("R3 ctrl mask", {32'b0, d}, {32'b0, ctrl_rb(32'hFFFF_FFFF)});
    wr(5'h0C, 32'h0000_0102);
    chk("R3 cfg_valid", {63'b0, cfg_valid}, 64'd1);
    chk("R3 algo", {62'b0, cfg_algo}, 64'd2);
    chk("R3 order", {62'b0, cfg_order}, 64'd1);

    // R9 clear, then R8 no effect once configured
    wr(5'h18, 32'hF); ms = '0;
    pulse_msg();
    stat_chk("R8 configured no effect");

    // R11 write to status ignored
    pulse_msg();
    wr(5'h10, 32'h1FF);
    stat_chk("R11 status write ignored");

    // R6 empty pop
    pop_chk("R6 empty pop returns 0");
    stat_chk("R6 read error bit");
    wr(5'h18, 32'h4); ms[2] = 1'b0;

    // R5 / R7 fill eight words, extra push refused
    for (int i = 0; i < 8; i++) push(32'hA000_0000 + 32'(i), i == 7);
    stat_chk("R7 avail and done bits");
    chk("R5 full not ready", {63'b0, dig_ready}, 64'd0);
    push(32'hDEAD_BEEF, 1'b0);
    for (int i = 0; i < 8; i++) pop_chk("R5 pop order");
    stat_chk("R10 level bit after drain");

    // R9 clear collides with done event
    wr(5'h18, 32'hF); ms = '0;
    reg_wr_en = 1'b1; reg_addr = 5'h18; reg_wdata = 32'h3;
    dig_valid = 1'b1; dig_data = 32'h1234_5678; dig_last = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; dig_valid = 1'b0; dig_last = 1'b0;
    mq.push_back(32'h1234_5678); ms[1:0] = 2'b11;
    stat_chk("R9 event wins over clear");

    // R10 irq follows enables
    wr(5'h14, 32'h100); men = 9'h100;
    chk("R10 irq level bit", {63'b0, irq}, {63'b0, exp_irq()});
    wr(5'h18, 32'h1FF); ms = '0;
    stat_chk("R10 level survives clear");
    wr(5'h14, 32'h001); men = 9'h001;
    chk("R10 irq masked", {63'b0, irq}, {63'b0, exp_irq()});

    // R4 soft reset
    push(32'h5555_AAAA, 1'b0);
    wr(5'h00, 32'h1);
    @(negedge clk);
    chk("R4 core_rst held", {63'b0, core_rst}, 64'd1);
    chk("R4 ready low", {63'b0, dig_ready}, 64'd0);
    chk("R4 cfg cleared", {63'b0, cfg_valid}, 64'd0);
    rd(5'h10, d); chk("R4 status cleared", {32'b0, d}, 64'd0);
    wr(5'h00, 32'h0);
    mq.delete(); ms = '0; mcfg = 1'b0;
    chk("R4 released", {63'b0, core_rst}, 64'd0);
    chk("R4 length kept", cfg_len, {h, l});
    pop_chk("R4 queue emptied");
    wr(5'h18, 32'h4); ms[2] = 1'b0;

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0, 1, 2: push($urandom(), $urandom_range(0, 3) == 0);
        3, 4:    pop_chk("R5 random pop");
        5:       stat_chk("R7 random status");
        6: begin d = $urandom(); wr(5'h18, d); ms = ms & ~d[3:0]; end
        7: begin d = $urandom(); wr(5'h14, d); men = d[8:0]; end
        8: pulse_msg();
        default: begin
          if ($urandom_range(0, 1) == 0) soft_reset();
          else begin wr(5'h0C, $urandom()); mcfg = 1'b1; end
        end
      endcase
      chk("R10 random irq", {63'b0, irq}, {63'b0, exp_irq()});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule